// File: doc/BRIEF.md
# Block-Ack Transmit Window Tracker

This block follows the transmit and acknowledge state of one aggregation queue that runs in window mode. Frames carry 12-bit sequence numbers. The block keeps a sliding window of up to 64 consecutive frames. For each frame it stores whether the frame is currently on the air (sent) and whether the receiver has confirmed it (acked).

New frames join the window when their first transmit-done event arrives. A block-ack report carries a starting sequence number and a 64-bit bitmap. Each report is matched against the window:
- A confirmed frame produces one completion event. Completions can appear out of sequence order.
- A frame that was sent but left unconfirmed is handed back as a retransmit request.

The window start moves forward over the leading frames that are confirmed and already reported. Their slots are then reused for later sequence numbers.

A load strobe sets a new window start and drops all tracked state. The frame window limit is a 7-bit setting. While the number of frames in flight has reached that limit, the block refuses new frames.

Top module: `ba_window_tracker`

## Requirements
- R1: After reset the window start is 0 and no frames are in flight. No retransmit or completion pulse is given, and `win_full` is low whenever `cfg_win_size` is nonzero.
- R2: A transmit-done event admits a new frame only when its sequence number equals window start plus frames in flight and `win_full` is low. Admission raises `inflight` by one. A transmit-done event for any other sequence number outside the window is ignored.
- R3: `win_full` is high exactly when `inflight` is at least the effective window size. The effective size is `cfg_win_size` clamped to 64, so a setting of 0 keeps the window full. `inflight` never exceeds 64.
- R4: Bitmap bit i of a block-ack report refers to sequence (ssn + i) mod 4096. A set bit on a frame that is in the window, sent and not yet acked marks the frame acked. Such a frame gives exactly one completion pulse carrying its sequence number.
- R5: A clear bit on a frame that is in the window, sent and not acked gives exactly one retransmit pulse with that sequence number. The frame then counts as unsent until a later transmit-done event for that sequence number.
- R6: The following bits have no effect: bits that map outside the window, bits for frames currently unsent, and bits for frames already acked. No further pulses follow from them.
- R7: While the frame at the window start is acked and its completion has been given, the window start advances by one per cycle and `inflight` drops by one per step.
- R8: Sequence arithmetic wraps modulo 4096 in the window start, in the bitmap mapping and in admission.
- R9: When a transmit-done event and a block-ack report arrive in the same cycle, the report is judged on the state before that cycle. A frame admitted in that cycle is therefore not affected by the report. If a frame is reported as missing but is retransmitted in that same cycle, it stays sent and gives no retransmit pulse.
- R10: A load strobe sets the window start to `start_seq` and empties the window. Any retransmit or completion still pending is dropped, and no pulse is given on the following cycle.
- R11: At most one retransmit pulse and one completion pulse are given per cycle. Among pending frames, each is given in order of increasing distance from the window start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_win_size | input | 7 | Window size limit in frames (clamped to 64) |
| start_load | input | 1 | Load a new window start and clear all state |
| start_seq | input | 12 | Window start applied on `start_load` |
| tx_done | input | 1 | A frame finished transmission |
| tx_seq | input | 12 | Sequence number of the transmitted frame |
| ba_valid | input | 1 | A block-ack report is present |
| ba_ssn | input | 12 | Starting sequence number of the report |
| ba_bitmap | input | 64 | Ack bits; bit i is sequence ssn + i |
| retry_valid | output | 1 | One-cycle retransmit request |
| retry_seq | output | 12 | Sequence number to retransmit |
| done_valid | output | 1 | One-cycle completion event |
| done_seq | output | 12 | Sequence number that completed |
| win_start | output | 12 | Current window start |
| inflight | output | 7 | Frames currently held in the window |
| win_full | output | 1 | Window limit reached; new frames refused |

## Verification
The bench drives a transmit-done event and a block-ack report in the same clock cycle, in two cases:
- The transmit-done event admits the next new frame while the report carries a set bit for that very sequence number. The bench then expects no completion for the new frame.
- The transmit-done event retransmits a frame that the report marks as missing. The bench expects no retransmit request for that frame, while a second missing frame in the same report still produces its request.

The final report then acks both frames. The bench judges the completion order and the window start that follows.

// File: rtl/ba_trk_pkg.sv
// Package: shared defaults and the per-slot state record of the window tracker.
// Assumes power-of-two window depth so slot index equals the low sequence bits.
package ba_trk_pkg;

    localparam int DEF_SEQ_W   = 12;
    localparam int DEF_WIN_MAX = 64;
    localparam int DEF_CFG_W   = 7;

    // State kept for one window slot.
    typedef struct packed {
        logic sent;    // frame currently transmitted and awaiting a verdict
        logic acked;   // receiver confirmed the frame
        logic rtx;     // retransmit request pending
        logic cmp;     // completion event pending
    } slot_st_t;

endpackage

// File: rtl/ba_slot_array.sv
// Module: bank of per-slot status registers for the window.
// Each slot is updated from one-hot/bit-vector commands computed by the top.
// Assumes free and clear_all override every other command for a slot.
module ba_slot_array
    import ba_trk_pkg::*;
#(
    parameter int N = DEF_WIN_MAX
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_all,
    input  logic [N-1:0] free,
    input  logic [N-1:0] set_sent,
    input  logic [N-1:0] ack,
    input  logic [N-1:0] nack,
    input  logic [N-1:0] clr_rtx,
    input  logic [N-1:0] clr_cmp,
    output logic [N-1:0] sent_q,
    output logic [N-1:0] acked_q,
    output logic [N-1:0] rtx_q,
    output logic [N-1:0] cmp_q
);

    for (genvar g = 0; g < N; g++) begin : g_slot
        slot_st_t st;

        // Update one slot: release wins, then merge transmit and report verdicts.
        always_ff @(posedge clk) begin
            if (!rst_n || clear_all || free[g]) begin
                st <= '0;
            end else begin
                st.sent  <= (st.sent & ~nack[g]) | set_sent[g];
                st.acked <= st.acked | ack[g];
                st.rtx   <= (st.rtx & ~clr_rtx[g] & ~set_sent[g]) | (nack[g] & ~set_sent[g]);
                st.cmp   <= (st.cmp & ~clr_cmp[g]) | ack[g];
            end
        end

        assign sent_q[g]  = st.sent;
        assign acked_q[g] = st.acked;
        assign rtx_q[g]   = st.rtx;
        assign cmp_q[g]   = st.cmp;
    end

endmodule

// File: rtl/ba_ack_map.sv
// Module: maps a block-ack bitmap onto physical window slots.
// For each slot it derives the slot's sequence number from the window start,
// checks window membership and bitmap coverage, and emits ack / nack hits for
// frames that are sent and not yet acked. Purely combinational.
module ba_ack_map #(
    parameter int SEQ_W  = 12,
    parameter int N      = 64,
    parameter int SLOT_W = $clog2(N),
    parameter int CNT_W  = $clog2(N + 1)
) (
    input  logic             ba_valid,
    input  logic [SEQ_W-1:0] ba_ssn,
    input  logic [N-1:0]     ba_bitmap,
    input  logic [SEQ_W-1:0] win_start,
    input  logic [CNT_W-1:0] inflight,
    input  logic [N-1:0]     sent_q,
    input  logic [N-1:0]     acked_q,
    output logic [N-1:0]     ack_hit,
    output logic [N-1:0]     nack_hit
);

    for (genvar g = 0; g < N; g++) begin : g_map
        logic [SLOT_W-1:0] off;
        logic [SEQ_W-1:0]  seq;
        logic [SEQ_W-1:0]  bidx;
        logic              in_win;
        logic              covered;
        logic              live;

        // Work out which sequence this slot holds and what the report says of it.
        always_comb begin
            off      = SLOT_W'(g) - win_start[SLOT_W-1:0];
            seq      = win_start + SEQ_W'(off);
            bidx     = seq - ba_ssn;
            in_win   = CNT_W'(off) < inflight;
            covered  = bidx < SEQ_W'(N);
            live     = ba_valid & in_win & covered & sent_q[g] & ~acked_q[g];
            ack_hit[g]  = live &  ba_bitmap[bidx[SLOT_W-1:0]];
            nack_hit[g] = live & ~ba_bitmap[bidx[SLOT_W-1:0]];
        end
    end

endmodule

// File: rtl/ba_oldest_pick.sv
// Module: finds the pending slot nearest to the window start.
// Scans offsets from the base in circular order; lowest offset wins.
module ba_oldest_pick #(
    parameter int N      = 64,
    parameter int SLOT_W = $clog2(N)
) (
    input  logic [N-1:0]      req,
    input  logic [SLOT_W-1:0] base,
    output logic              found,
    output logic [SLOT_W-1:0] off
);

    // Walk offsets from the far end so the nearest request is kept last.
    always_comb begin
        found = 1'b0;
        off   = '0;
        for (int o = N - 1; o >= 0; o--) begin
            if (req[base + SLOT_W'(o)]) begin
                found = 1'b1;
                off   = SLOT_W'(o);
            end
        end
    end

endmodule

// File: rtl/ba_window_tracker.sv
// Module: block-ack transmit window tracker for one aggregation queue.
// Admits new frames in sequence order, applies block-ack reports to the
// per-frame sent/acked state, issues retransmit and completion pulses one of
// each per cycle, and slides the window over finished leading frames.
// Assumes WIN_MAX is a power of two not larger than half the sequence space.
module ba_window_tracker
    import ba_trk_pkg::*;
#(
    parameter int SEQ_W   = DEF_SEQ_W,
    parameter int WIN_MAX = DEF_WIN_MAX,
    parameter int CFG_W   = DEF_CFG_W,
    localparam int SLOT_W = $clog2(WIN_MAX),
    localparam int CNT_W  = $clog2(WIN_MAX + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CFG_W-1:0]   cfg_win_size,
    input  logic               start_load,
    input  logic [SEQ_W-1:0]   start_seq,
    input  logic               tx_done,
    input  logic [SEQ_W-1:0]   tx_seq,
    input  logic               ba_valid,
    input  logic [SEQ_W-1:0]   ba_ssn,
    input  logic [WIN_MAX-1:0] ba_bitmap,
    output logic               retry_valid,
    output logic [SEQ_W-1:0]   retry_seq,
    output logic               done_valid,
    output logic [SEQ_W-1:0]   done_seq,
    output logic [SEQ_W-1:0]   win_start,
    output logic [CNT_W-1:0]   inflight,
    output logic               win_full
);

    localparam logic [WIN_MAX-1:0] ONE = WIN_MAX'(1);

    logic [SEQ_W-1:0]   start_q;
    logic [CNT_W-1:0]   inflight_q;
    logic [CNT_W-1:0]   eff_size;
    logic [SEQ_W-1:0]   tx_off;
    logic               tx_new;
    logic               tx_old;
    logic               slide;
    logic [SLOT_W-1:0]  head;
    logic [WIN_MAX-1:0] sent_q, acked_q, rtx_q, cmp_q;
    logic [WIN_MAX-1:0] ack_hit, nack_hit;
    logic [WIN_MAX-1:0] set_sent_v, free_v, clr_rtx_v, clr_cmp_v;
    logic               rtx_found, cmp_found;
    logic [SLOT_W-1:0]  rtx_off, cmp_off;

    assign head = start_q[SLOT_W-1:0];

    // Clamp the configured window size to the slot count.
    always_comb begin
        if (int'(cfg_win_size) > WIN_MAX) eff_size = CNT_W'(WIN_MAX);
        else                              eff_size = CNT_W'(cfg_win_size);
    end

    assign win_full = inflight_q >= eff_size;

    // Classify a transmit-done event as new admission, retransmit or stray.
    always_comb begin
        tx_off = tx_seq - start_q;
        tx_new = tx_done & ~start_load & ~win_full & (tx_off == SEQ_W'(inflight_q));
        tx_old = tx_done & ~start_load & (tx_off < SEQ_W'(inflight_q))
               & ~acked_q[tx_seq[SLOT_W-1:0]];
        set_sent_v = (tx_new | tx_old) ? (ONE << tx_seq[SLOT_W-1:0]) : '0;
    end

    // Release the head slot once it is acked and its completion has gone out.
    always_comb begin
        slide  = ~start_load & (inflight_q != '0) & acked_q[head] & ~cmp_q[head];
        free_v = slide ? (ONE << head) : '0;
    end

    // Clear the pending flags of the slots picked for output this cycle.
    always_comb begin
        clr_rtx_v = (rtx_found & ~start_load) ? (ONE << (head + rtx_off)) : '0;
        clr_cmp_v = (cmp_found & ~start_load) ? (ONE << (head + cmp_off)) : '0;
    end

    ba_ack_map #(
        .SEQ_W (SEQ_W),
        .N     (WIN_MAX),
        .SLOT_W(SLOT_W),
        .CNT_W (CNT_W)
    ) u_map (
        .ba_valid (ba_valid & ~start_load),
        .ba_ssn   (ba_ssn),
        .ba_bitmap(ba_bitmap),
        .win_start(start_q),
        .inflight (inflight_q),
        .sent_q   (sent_q),
        .acked_q  (acked_q),
        .ack_hit  (ack_hit),
        .nack_hit (nack_hit)
    );

    ba_slot_array #(
        .N(WIN_MAX)
    ) u_slots (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_all(start_load),
        .free     (free_v),
        .set_sent (set_sent_v),
        .ack      (ack_hit),
        .nack     (nack_hit),
        .clr_rtx  (clr_rtx_v),
        .clr_cmp  (clr_cmp_v),
        .sent_q   (sent_q),
        .acked_q  (acked_q),
        .rtx_q    (rtx_q),
        .cmp_q    (cmp_q)
    );

    ba_oldest_pick #(
        .N     (WIN_MAX),
        .SLOT_W(SLOT_W)
    ) u_pick_rtx (
        .req  (rtx_q),
        .base (head),
        .found(rtx_found),
        .off  (rtx_off)
    );

    ba_oldest_pick #(
        .N     (WIN_MAX),
        .SLOT_W(SLOT_W)
    ) u_pick_cmp (
        .req  (cmp_q),
        .base (head),
        .found(cmp_found),
        .off  (cmp_off)
    );

    // Window start and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q    <= '0;
            inflight_q <= '0;
        end else if (start_load) begin
            start_q    <= start_seq;
            inflight_q <= '0;
        end else begin
            if (slide) start_q <= start_q + SEQ_W'(1);
            inflight_q <= inflight_q + CNT_W'(tx_new) - CNT_W'(slide);
        end
    end

    // Registered retransmit and completion pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            retry_valid <= 1'b0;
            retry_seq   <= '0;
            done_valid  <= 1'b0;
            done_seq    <= '0;
        end else begin
            retry_valid <= rtx_found & ~start_load;
            retry_seq   <= start_q + SEQ_W'(rtx_off);
            done_valid  <= cmp_found & ~start_load;
            done_seq    <= start_q + SEQ_W'(cmp_off);
        end
    end

    assign win_start = start_q;
    assign inflight  = inflight_q;

endmodule

// File: rtl/ba_window_tracker_chk.sv
// Module: temporal checks on the window tracker's ports, bound to every instance.
module ba_window_tracker_chk #(
    parameter int SEQ_W   = 12,
    parameter int WIN_MAX = 64,
    parameter int CNT_W   = $clog2(WIN_MAX + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_load,
    input logic [SEQ_W-1:0] start_seq,
    input logic             retry_valid,
    input logic [SEQ_W-1:0] retry_seq,
    input logic             done_valid,
    input logic [SEQ_W-1:0] done_seq,
    input logic [SEQ_W-1:0] win_start,
    input logic [CNT_W-1:0] inflight,
    input logic             win_full
);

    logic [SEQ_W-1:0] done_dist;
    logic [SEQ_W-1:0] retry_dist;

    // Distance of each emitted sequence from the window start.
    always_comb begin
        done_dist  = done_seq - win_start;
        retry_dist = retry_seq - win_start;
    end

    p_done_in_win_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> (done_dist < SEQ_W'(inflight)));

    p_retry_in_win_r5: assert property (@(posedge clk) disable iff (!rst_n)
        retry_valid |-> (retry_dist < SEQ_W'(inflight)));

    p_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        inflight <= CNT_W'(WIN_MAX));

    p_full_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (win_full && !start_load) |=> (inflight <= $past(inflight)));

    p_slide_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(start_load) && (win_start != $past(win_start)))
            |-> (win_start == SEQ_W'($past(win_start) + 1'b1)));

    p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_load |=> ((win_start == $past(start_seq)) && (inflight == '0)
                        && !retry_valid && !done_valid));

endmodule

bind ba_window_tracker ba_window_tracker_chk #(
    .SEQ_W  (SEQ_W),
    .WIN_MAX(WIN_MAX)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_load (start_load),
    .start_seq  (start_seq),
    .retry_valid(retry_valid),
    .retry_seq  (retry_seq),
    .done_valid (done_valid),
    .done_seq   (done_seq),
    .win_start  (win_start),
    .inflight   (inflight),
    .win_full   (win_full)
);

// File: tb/sim_ba_window_tracker.sv
`timescale 1ns/1ps
module sim_ba_window_tracker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  cfg_win_size = 7'd8;
    logic        start_load = 1'b0;
    logic [11:0] start_seq = '0;
    logic        tx_done = 1'b0;
    logic [11:0] tx_seq = '0;
    logic        ba_valid = 1'b0;
    logic [11:0] ba_ssn = '0;
    logic [63:0] ba_bitmap = '0;
    logic        retry_valid;
    logic [11:0] retry_seq;
    logic        done_valid;
    logic [11:0] done_seq;
    logic [11:0] win_start;
    logic [6:0]  inflight;
    logic        win_full;

    int checks = 0;
    int fails  = 0;
    int done_log [0:255];
    int retry_log [0:255];
    int done_n  = 0;
    int retry_n = 0;

    always #2.5 clk = ~clk;

    ba_window_tracker u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_win_size(cfg_win_size),
        .start_load  (start_load),
        .start_seq   (start_seq),
        .tx_done     (tx_done),
        .tx_seq      (tx_seq),
        .ba_valid    (ba_valid),
        .ba_ssn      (ba_ssn),
        .ba_bitmap   (ba_bitmap),
        .retry_valid (retry_valid),
        .retry_seq   (retry_seq),
        .done_valid  (done_valid),
        .done_seq    (done_seq),
        .win_start   (win_start),
        .inflight    (inflight),
        .win_full    (win_full)
    );

    // Record every output pulse away from the active edge.
    always @(negedge clk) begin
        if (rst_n && done_valid && done_n < 256) begin
            done_log[done_n] = int'(done_seq);
            done_n++;
        end
        if (rst_n && retry_valid && retry_n < 256) begin
            retry_log[retry_n] = int'(retry_seq);
            retry_n++;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_logs();
        done_n  = 0;
        retry_n = 0;
    endtask

    task automatic do_load(int seq, int size);
        cfg_win_size = 7'(size);
        start_seq    = 12'(seq);
        start_load   = 1'b1;
        tick();
        start_load   = 1'b0;
        tick();
    endtask

    task automatic send(int seq);
        tx_done = 1'b1;
        tx_seq  = 12'(seq);
        tick();
        tx_done = 1'b0;
    endtask

    task automatic report(int ssn, logic [63:0] bmp);
        ba_valid  = 1'b1;
        ba_ssn    = 12'(ssn);
        ba_bitmap = bmp;
        tick();
        ba_valid  = 1'b0;
    endtask

    task automatic settle();
        repeat (24) tick();
    endtask

    task automatic t_reset();
        chk("R1", "win_start", int'(win_start), 0);
        chk("R1", "inflight", int'(inflight), 0);
        chk("R1", "win_full", int'(win_full), 0);
        chk("R1", "retry_valid", int'(retry_valid), 0);
        chk("R1", "done_valid", int'(done_valid), 0);
    endtask

    task automatic t_admit();
        do_load(100, 8);
        send(105);
        chk("R2", "inflight after out-of-order new seq", int'(inflight), 0);
        for (int i = 0; i < 7; i++) send(100 + i);
        chk("R3", "win_full at 7 of 8", int'(win_full), 0);
        send(107);
        chk("R2", "inflight after 8 frames", int'(inflight), 8);
        chk("R3", "win_full at 8 of 8", int'(win_full), 1);
        send(108);
        chk("R2", "inflight after refused frame", int'(inflight), 8);
    endtask

    task automatic t_mixed_report();
        clear_logs();
        report(100, 64'hFFFF_FFFF_FFFF_FF0B);
        settle();
        chk("R4", "completion count", done_n, 3);
        chk("R11", "completion 0", done_log[0], 100);
        chk("R11", "completion 1", done_log[1], 101);
        chk("R11", "completion 2", done_log[2], 103);
        chk("R5", "retransmit count", retry_n, 5);
        chk("R11", "retransmit 0", retry_log[0], 102);
        chk("R11", "retransmit 1", retry_log[1], 104);
        chk("R11", "retransmit 4", retry_log[4], 107);
        chk("R7", "win_start after slide", int'(win_start), 102);
        chk("R7", "inflight after slide", int'(inflight), 6);
        chk("R3", "win_full after slide", int'(win_full), 0);
    endtask

    task automatic t_ignore_and_offset();
        clear_logs();
        report(100, 64'hFFFF_FFFF_FFFF_FF0B);
        settle();
        chk("R6", "pulses from repeated report", done_n + retry_n, 0);
        send(102);
        report(102, 64'h1);
        settle();
        chk("R5", "completion after resend", done_n, 1);
        chk("R5", "resent seq completed", done_log[0], 102);
        chk("R7", "win_start past 102 and 103", int'(win_start), 104);
        chk("R7", "inflight", int'(inflight), 4);
        clear_logs();
        for (int i = 104; i < 108; i++) send(i);
        report(90, 64'h8000);
        settle();
        chk("R4", "offset ssn completion count", done_n, 1);
        chk("R4", "offset ssn completion seq", done_log[0], 105);
        chk("R5", "offset ssn retransmit count", retry_n, 3);
        chk("R11", "offset ssn retransmit order", retry_log[1], 106);
        chk("R7", "win_start held", int'(win_start), 104);
    endtask

    task automatic t_wrap();
        do_load(4090, 10);
        clear_logs();
        for (int i = 0; i < 10; i++) send((4090 + i) % 4096);
        chk("R8", "full across wrap", int'(win_full), 1);
        report(4094, '1);
        settle();
        chk("R8", "completions across wrap", done_n, 6);
        chk("R8", "first completion", done_log[0], 4094);
        chk("R8", "third completion", done_log[2], 0);
        chk("R6", "uncovered frames give no retransmit", retry_n, 0);
        chk("R7", "start held by unacked head", int'(win_start), 4090);
        report(4090, 64'h3FF);
        settle();
        chk("R6", "already acked bits ignored", done_n, 10);
        chk("R8", "win_start wrapped", int'(win_start), 4);
        chk("R7", "inflight drained", int'(inflight), 0);
    endtask

    task automatic t_same_cycle();
        do_load(200, 4);
        clear_logs();
        send(200);
        send(201);
        tx_done = 1'b1; tx_seq = 12'd202;
        ba_valid = 1'b1; ba_ssn = 12'd200; ba_bitmap = 64'h5;
        tick();
        tx_done = 1'b0; ba_valid = 1'b0;
        settle();
        chk("R9", "completions", done_n, 1);
        chk("R9", "completion seq", done_log[0], 200);
        chk("R9", "retransmit count", retry_n, 1);
        chk("R9", "retransmit seq", retry_log[0], 201);
        chk("R9", "inflight incl. admitted", int'(inflight), 2);
        send(201);
        tx_done = 1'b1; tx_seq = 12'd201;
        ba_valid = 1'b1; ba_ssn = 12'd201; ba_bitmap = 64'h0;
        tick();
        tx_done = 1'b0; ba_valid = 1'b0;
        settle();
        chk("R9", "retransmit count after override", retry_n, 2);
        chk("R9", "only the other frame retried", retry_log[1], 202);
        send(202);
        report(200, 64'h7);
        settle();
        chk("R9", "final completions", done_n, 3);
        chk("R11", "completion order", done_log[1], 201);
        chk("R7", "final win_start", int'(win_start), 203);
    endtask

    task automatic t_load_cancel();
        do_load(300, 3);
        clear_logs();
        for (int i = 300; i < 303; i++) send(i);
        report(300, 64'h0);
        cfg_win_size = 7'd8;
        start_seq    = 12'd500;
        start_load   = 1'b1;
        tick();
        start_load   = 1'b0;
        settle();
        chk("R10", "pulses after load", retry_n + done_n, 0);
        chk("R10", "win_start", int'(win_start), 500);
        chk("R10", "inflight", int'(inflight), 0);
        chk("R10", "win_full", int'(win_full), 0);
    endtask

    task automatic t_clamp();
        do_load(0, 100);
        for (int i = 0; i < 63; i++) send(i);
        chk("R3", "not full at 63 with size 100", int'(win_full), 0);
        send(63);
        chk("R3", "full at 64 with size 100", int'(win_full), 1);
        send(64);
        chk("R3", "inflight capped", int'(inflight), 64);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        #1_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        tick();
        t_reset();
        t_admit();
        t_mixed_report();
        t_ignore_and_offset();
        t_wrap();
        t_same_cycle();
        t_load_cancel();
        t_clamp();
        finish_run();
    end

endmodule